// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block watches eight interrupt request lines, latches them into a pending register and decides, every clock, whether a single interrupt output should be raised and which line has won. Each line is configured as edge-sensitive (a rising edge latches a request that stays until acknowledged) or level-sensitive (the pending bit mirrors the line). The winner is chosen by a priority order that rotates with a programmable base, and it is only presented when it outranks everything currently in service.

The surrounding controller owns the mask, in-service, trigger-mode and rotation state and feeds them in as plain inputs. It also returns an acknowledge strobe with a line index; this clears a latched edge request, while level requests are left to follow their lines. Two modifiers change how the in-service set is compared: a special-mask flag that hides masked in-service bits, and a nested flag that, on the master unit, hides the in-service bit of the cascade input (line 2).

Top module: `irq_priority_resolver`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears the pending register and the stored previous line levels and drives irq_out to 0 and irq_line to 0; a line already high when reset is released counts as a rising edge.
- R2: A line whose trig_level bit is 0 sets its pending bit only when it is high in a cycle after it was low; a line held high does not set the bit again after it is cleared.
- R3: A line whose trig_level bit is 1 has its pending bit equal to the line in every cycle, set and cleared by the line alone; an acknowledge of that line has no effect.
- R4: ack_en high with ack_idx = i clears the pending bit of edge-mode line i, unless that line rises in the same cycle, in which case the bit stays set.
- R5: A line whose mask bit is 1 never wins, whatever its pending state.
- R6: Line (p + rot_base) mod 8 has priority p, priority 0 is the highest, and the highest-priority unmasked pending line is reported on irq_line.
- R7: irq_out is 1 only when the best unmasked pending priority is strictly numerically smaller than the best priority of the in-service set; an in-service line of equal or higher priority blocks it.
- R8: With spec_mask = 1, in-service bits whose mask bit is 1 are left out of the in-service priority.
- R9: With nested_mode = 1 and is_master = 1, in-service bit 2 is left out of the in-service priority; with is_master = 0 it counts.
- R10: irq_out and irq_line are registered: they reflect the inputs sampled at a clock edge and change only at that edge; irq_line is 0 whenever irq_out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 8 | Request lines, synchronous to clk |
| trig_level | input | 8 | Per line: 1 = level-sensitive, 0 = edge-sensitive |
| mask | input | 8 | Per line: 1 = masked |
| in_service | input | 8 | Lines currently being serviced |
| rot_base | input | 3 | Line that holds priority 0 |
| spec_mask | input | 1 | Leave masked in-service bits out of the comparison |
| nested_mode | input | 1 | Leave the cascade in-service bit out (master only) |
| is_master | input | 1 | Unit is the master of a cascade |
| ack_en | input | 1 | Acknowledge strobe |
| ack_idx | input | 3 | Line being acknowledged |
| irq_out | output | 1 | Interrupt request, also the valid flag for irq_line |
| irq_line | output | 3 | Winning line number |

## Verification
The embedded assertions check on every cycle that edge-mode bits do not re-latch on a held-high line, that level-mode bits track their line, that an acknowledge clears an edge request, that a raised output never names a masked or non-pending line, and that irq_line rests at 0 when nothing is raised. Whether the rotated order picks the right line, whether the strict comparison against the in-service set blocks equal priorities, and how the special-mask and nested modifiers change that comparison can only be shown by the bench's directed scenarios and its randomized run against the reference functions.

// File: rtl/irq_priority_resolver.sv
module irq_priority_resolver #(
  parameter int N       = 8,
  parameter int CASCADE = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req_in,
  input  logic [N-1:0]         trig_level,
  input  logic [N-1:0]         mask,
  input  logic [N-1:0]         in_service,
  input  logic [$clog2(N)-1:0] rot_base,
  input  logic                 spec_mask,
  input  logic                 nested_mode,
  input  logic                 is_master,
  input  logic                 ack_en,
  input  logic [$clog2(N)-1:0] ack_idx,
  output logic                 irq_out,
  output logic [$clog2(N)-1:0] irq_line
);
  localparam int IW = $clog2(N);
  localparam int PW = IW + 1;

  logic [N-1:0]  prev_q, pend_q, pend_nxt, rise, ack_vec, cand, isr_eff;
  logic [PW-1:0] pb, cb;
  logic          win;

  function automatic logic [PW-1:0] best(input logic [N-1:0] v, input logic [IW-1:0] off);
    best = PW'(N);
    for (int p = N - 1; p >= 0; p--)
      if (v[IW'(p) + off]) best = PW'(p);
  endfunction

  assign rise     = req_in & ~prev_q;
  assign ack_vec  = ack_en ? (N'(1) << ack_idx) : '0;
  assign pend_nxt = (trig_level & req_in) | (~trig_level & ((pend_q & ~ack_vec) | rise));
  assign cand     = pend_nxt & ~mask;

  always_comb begin
    isr_eff = in_service;
    if (spec_mask) isr_eff = isr_eff & ~mask;
    if (nested_mode && is_master) isr_eff[CASCADE] = 1'b0;
  end

  assign pb  = best(cand, rot_base);
  assign cb  = best(isr_eff, rot_base);
  assign win = pb < cb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      pend_q   <= '0;
      irq_out  <= 1'b0;
      irq_line <= '0;
    end else begin
      prev_q   <= req_in;
      pend_q   <= pend_nxt;
      irq_out  <= win;
      irq_line <= win ? pb[IW-1:0] + rot_base : '0;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_edge_no_relatch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(trig_level[i]) && $past(prev_q[i]) && !$past(pend_q[i])
      |-> !pend_q[i]);
    assert_level_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(trig_level[i]) |-> pend_q[i] == $past(req_in[i]));
    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(ack_en) && $past(ack_idx) == IW'(i) && !$past(trig_level[i])
      && !($past(req_in[i]) && !$past(prev_q[i])) |-> !pend_q[i]);
  end

  assert_winner_unmasked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && irq_out |-> (($past(mask) >> irq_line) & N'(1)) == '0);
  assert_winner_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> pend_q[irq_line]);
  assert_idle_line_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out |-> irq_line == '0);
endmodule

// File: tb/irq_priority_resolver_test.sv
module irq_priority_resolver_test;
  logic       clk = 0, rst_n = 0;
  logic [7:0] req_in = 0, trig_level = 0, mask = 0, in_service = 0;
  logic [2:0] rot_base = 0, ack_idx = 0;
  logic       spec_mask = 0, nested_mode = 0, is_master = 0, ack_en = 0;
  logic       irq_out;
  logic [2:0] irq_line;
  logic [7:0] m_prev = 0, m_pend = 0;
  int checks = 0, fails = 0;

  irq_priority_resolver uut (.*);

  always #10 clk = ~clk;

  function automatic int mprio(input logic [7:0] v, input logic [2:0] off);
    for (int p = 0; p < 8; p++) if (v[(p + off) % 8]) return p;
    return 8;
  endfunction

  task automatic chk(input string tag, input logic ei, input logic [2:0] el);
    checks++;
    if (irq_out !== ei || irq_line !== el) begin
      fails++;
      $display("FAIL %s: irq_out=%0b irq_line=%0d expected irq_out=%0b irq_line=%0d",
               tag, irq_out, irq_line, ei, el);
    end
  endtask

  task automatic step(input string tag);
    logic [7:0] nx, isr;
    int pb, cb;
    logic ei;
    logic [2:0] el;
    for (int i = 0; i < 8; i++)
      if (trig_level[i]) nx[i] = req_in[i];
      else nx[i] = (m_pend[i] && !(ack_en && ack_idx == i)) || (req_in[i] && !m_prev[i]);
    isr = in_service;
    if (spec_mask) isr = isr & ~mask;
    if (nested_mode && is_master) isr[2] = 1'b0;
    pb = mprio(nx & ~mask, rot_base);
    cb = mprio(isr, rot_base);
    ei = pb < cb;
    el = ei ? 3'((pb + rot_base) % 8) : 3'd0;
    m_prev = req_in;
    m_pend = nx;
    @(posedge clk); #2;
    chk(tag, ei, el);
    @(negedge clk);
  endtask

  task automatic clear_inputs();
    req_in = 0; trig_level = 0; mask = 0; in_service = 0; rot_base = 0;
    spec_mask = 0; nested_mode = 0; is_master = 0; ack_en = 0; ack_idx = 0;
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset state", 1'b0, 3'd0);
    rst_n = 1;

    // R2 edge latch, R4 ack clear, no relatch while held
    req_in = 8'h08; step("R2 rising edge line 3");
    ack_en = 1; ack_idx = 3; step("R4 ack clears edge request");
    ack_en = 0; step("R2 held high does not relatch");
    req_in = 0; step("R2 line falls");
    req_in = 8'h08; ack_en = 1; ack_idx = 3; step("R4 rise beats ack same cycle");
    ack_en = 0; req_in = 0; ack_en = 1; step("R4 ack after rise");
    clear_inputs();

    // R3 level mode
    trig_level = 8'h20; req_in = 8'h20; step("R3 level line 5 high");
    ack_en = 1; ack_idx = 5; step("R3 ack ignored on level line");
    ack_en = 0; req_in = 0; step("R3 level line drops");

    // R10 latency: no change before the edge
    req_in = 8'h20; #5;
    chk("R10 output waits for clock edge", 1'b0, 3'd0);
    step("R10 output after edge");
    clear_inputs(); step("R3 cleared");

    // R5 masking
    trig_level = 8'hFF; req_in = 8'h12; mask = 8'h02; step("R5 masked line 1 skipped");
    mask = 8'h12; step("R5 all pending masked");
    mask = 0; step("R6 line 1 wins at base 0");

    // R6 rotation
    req_in = 8'h42; rot_base = 2; step("R6 base 2 picks line 6");
    rot_base = 7; step("R6 base 7 picks line 1");
    rot_base = 6; step("R6 base 6 picks line 6");

    // R7 strict comparison
    req_in = 8'h10; rot_base = 0; in_service = 8'h10; step("R7 equal priority blocks");
    in_service = 8'h04; step("R7 higher in-service blocks");
    in_service = 8'h40; step("R7 lower in-service allows");

    // R8 special mask
    req_in = 8'h20; in_service = 8'h08; mask = 8'h08; step("R8 off: masked isr counts");
    spec_mask = 1; step("R8 on: masked isr ignored");
    spec_mask = 0;

    // R9 nested on master
    mask = 0; req_in = 8'h10; in_service = 8'h04; nested_mode = 1; is_master = 1;
    step("R9 master ignores cascade isr");
    is_master = 0; step("R9 slave keeps cascade isr");
    nested_mode = 0; is_master = 1; step("R9 mode off keeps cascade isr");
    clear_inputs(); step("R10 idle line zero");

    // randomized mix
    for (int n = 0; n < 400; n++) begin
      req_in      = 8'($urandom);
      trig_level  = 8'($urandom);
      mask        = 8'($urandom & $urandom);
      in_service  = 8'($urandom & $urandom & $urandom);
      rot_base    = 3'($urandom);
      spec_mask   = 1'($urandom);
      nested_mode = 1'($urandom);
      is_master   = 1'($urandom);
      ack_en      = 1'($urandom);
      ack_idx     = 3'($urandom);
      step("R6 R7 random");
    end

    // R1 second reset clears stored levels
    clear_inputs(); req_in = 8'h01;
    rst_n = 0; @(posedge clk); #2;
    chk("R1 reset mid-run", 1'b0, 3'd0);
    @(negedge clk); rst_n = 1; m_prev = 0; m_pend = 0;
    step("R1 held-high line seen as edge after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule